// File: doc/BRIEF.md
# Seven-to-one serial lane transmitter

This block turns a 28-bit parallel word into four serial data lanes and one forwarded-clock lane. It runs on a single fast bit clock at seven times the word rate. An internal slot counter divides that clock into seven-slot frames. One slot of each frame is the word capture point, and the block flags it to the upstream logic on `word_take_o`, which stands in for the parallel clock's rising edge. The captured word sits in a holding register until the next frame boundary. At that boundary it moves into per-lane shift registers, so a word arriving early never disturbs the bits already being sent.

The forwarded-clock lane carries a fixed high-for-four, low-for-three pattern, aligned to the first bit slot of every frame. The outputs are enabled only once both conditions below hold:

- the bit-clock source reports lock and the active-low power-down pin is released;
- a parameterised number of frame boundaries has then passed.

Powering down or losing lock drops the output enable at once and forces every lane low. The output enable `oe_o` stands in for the high-impedance state of a real driver.

Top module: `ls7_serializer`

## Requirements
- R1: `word_i` is sampled on each rising `clk_i` edge where `word_take_o` is high. `word_take_o` is high exactly once every SLOTS (7) cycles, in slot CAP_SLOT (3) of the frame.
- R2: In slot j (0..6) of the frame after a capture, `lane_o[k]` carries bit 7k+j of the captured word, so bit 7k goes out first on lane k.
- R3: While enabled, `clk_lane_o` is high in slots 0 to 3 and low in slots 4 to 6 of every frame.
- R4: Changes on `word_i` in cycles where `word_take_o` is low have no effect on the serial output.
- R5: While `pdn_ni` is low, `oe_o`, every bit of `lane_o` and `clk_lane_o` are 0 in the same cycle, with no clock edge needed.
- R6: After reset, or after `pdn_ni` and `pll_lock_i` are both high again, `oe_o` rises at the LOCK_CYCLES-th frame boundary that follows. Straight out of reset with both inputs high, this is exactly LOCK_CYCLES*7 clock edges after reset release.
- R7: `oe_o` only rises at the start of a frame, in the same cycle as a rising `clk_lane_o`.
- R8: While `pll_lock_i` is low, `oe_o` is 0, and the lock delay restarts from zero.
- R9: While `rst_ni` is low, `oe_o`, `lane_o` and `clk_lane_o` are all 0.
- R10: The 28 bits carry no grouping. Walking-one, all-ones, alternating and nibble-count words all arrive unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock, seven times the word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_lock_i | input | 1 | Bit-clock source lock indication |
| pdn_ni | input | 1 | Power-down, active low |
| word_i | input | 28 | Parallel input word |
| word_take_o | output | 1 | High in the cycle whose closing edge samples `word_i` |
| lane_o | output | 4 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded clock lane |
| oe_o | output | 1 | Output enable (low models high impedance) |

## Verification
Assertions watch every cycle for the following:

- the spacing of capture strobes;
- the silence of all outputs during power-down, loss of lock, or while disabled;
- the four-cycle high run of the clock lane;
- the alignment of the enable's rise to a frame start.

Only the bench scenarios can show the lane-to-bit mapping, the immunity to changes on `word_i` between captures, and the exact start-up delay counted in cycles. For these, the bench rebuilds each frame from the lane pins and compares it with the word it offered at the capture slot.

// File: rtl/ls7_pkg.sv
package ls7_pkg;
  localparam int unsigned DEF_LANES    = 4;
  localparam int unsigned DEF_SLOTS    = 7;
  localparam int unsigned DEF_CAP_SLOT = 3;
  localparam int unsigned DEF_CLK_HIGH = 4;
  localparam int unsigned DEF_LOCK     = 16;

  typedef struct packed {
    logic take;   // capture slot
    logic tick;   // last slot, frame boundary on closing edge
    logic clk_hi; // forwarded clock level for this slot
  } slot_ev_t;
endpackage

// File: rtl/ls7_slot_timer.sv
module ls7_slot_timer
  import ls7_pkg::*;
#(
  parameter int unsigned SLOTS    = DEF_SLOTS,
  parameter int unsigned CAP_SLOT = DEF_CAP_SLOT,
  parameter int unsigned CLK_HIGH = DEF_CLK_HIGH
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output slot_ev_t ev_o
);
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam logic [SW-1:0] CAP  = SW'(CAP_SLOT);
  localparam logic [SW-1:0] HIGH = SW'(CLK_HIGH);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                    slot_q <= slot_q + 1'b1;
  end

  always_comb begin
    ev_o.take   = (slot_q == CAP);
    ev_o.tick   = (slot_q == LAST);
    ev_o.clk_hi = (slot_q < HIGH);
  end
endmodule

// File: rtl/ls7_lane_shifter.sv
module ls7_lane_shifter
  import ls7_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             tick_i,
  input  logic [SLOTS-1:0] bits_i,
  output logic             bit_o
);
  logic [SLOTS-1:0] hold_q;
  logic [SLOTS-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (take_i) hold_q <= bits_i;
  end

  // reload at frame boundary, lowest bit leaves first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (tick_i) shift_q <= hold_q;
    else             shift_q <= shift_q >> 1;
  end

  assign bit_o = shift_q[0];
endmodule

// File: rtl/ls7_enable_ctrl.sv
module ls7_enable_ctrl
  import ls7_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = DEF_LOCK
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic pdn_ni,
  input  logic tick_i,
  output logic oe_o
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LOCK_CYCLES - 1);

  logic          ok;
  logic [CW-1:0] cnt_q;
  logic          oe_q;

  assign ok = pdn_ni & pll_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (!ok) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (tick_i && !oe_q) begin
      cnt_q <= cnt_q + 1'b1;
      oe_q  <= (cnt_q == LAST_CNT);
    end
  end

  // drop without waiting for an edge
  assign oe_o = oe_q & ok;
endmodule

// File: rtl/ls7_serializer.sv
module ls7_serializer
  import ls7_pkg::*;
#(
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned SLOTS       = DEF_SLOTS,
  parameter int unsigned CAP_SLOT    = DEF_CAP_SLOT,
  parameter int unsigned CLK_HIGH    = DEF_CLK_HIGH,
  parameter int unsigned LOCK_CYCLES = DEF_LOCK,
  localparam int unsigned W          = LANES * SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pll_lock_i,
  input  logic             pdn_ni,
  input  logic [W-1:0]     word_i,
  output logic             word_take_o,
  output logic [LANES-1:0] lane_o,
  output logic             clk_lane_o,
  output logic             oe_o
);
  slot_ev_t         ev;
  logic [LANES-1:0] raw_bits;
  logic             oe;

  ls7_slot_timer #(
    .SLOTS   (SLOTS),
    .CAP_SLOT(CAP_SLOT),
    .CLK_HIGH(CLK_HIGH)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_o  (ev)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ls7_lane_shifter #(.SLOTS(SLOTS)) u_shift (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(ev.take),
      .tick_i(ev.tick),
      .bits_i(word_i[k*SLOTS +: SLOTS]),
      .bit_o (raw_bits[k])
    );
  end

  ls7_enable_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pll_lock_i(pll_lock_i),
    .pdn_ni    (pdn_ni),
    .tick_i    (ev.tick),
    .oe_o      (oe)
  );

  assign word_take_o = ev.take;
  assign oe_o        = oe;
  assign lane_o      = raw_bits & {LANES{oe}};
  assign clk_lane_o  = ev.clk_hi & oe;
endmodule

// File: rtl/ls7_serializer_chk.sv
module ls7_serializer_chk #(
  parameter int unsigned LANES    = 4,
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned CLK_HIGH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pll_lock_i,
  input logic             pdn_ni,
  input logic             word_take_o,
  input logic [LANES-1:0] lane_o,
  input logic             clk_lane_o,
  input logic             oe_o
);
  logic [7:0] gap_q;
  logic       seen_q;
  logic [7:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      seen_q   <= 1'b0;
      hi_run_q <= '0;
    end else begin
      if (word_take_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != 8'hff) begin
        gap_q <= gap_q + 1'b1;
      end
      hi_run_q <= clk_lane_o ? hi_run_q + 1'b1 : 8'd0;
    end
  end

  a_r1_take_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_take_o && seen_q) |-> (gap_q == 8'(SLOTS - 1)));

  a_r5_pdn_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_ni |-> (!oe_o && lane_o == '0 && !clk_lane_o));

  a_r8_lock_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |-> !oe_o);

  a_r7_oe_frame_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> clk_lane_o);

  a_r3_clk_high_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_lane_o) && oe_o) |-> (hi_run_q == 8'(CLK_HIGH)));

  a_r9_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (lane_o == '0 && !clk_lane_o));
endmodule

bind ls7_serializer ls7_serializer_chk #(
  .LANES   (LANES),
  .SLOTS   (SLOTS),
  .CLK_HIGH(CLK_HIGH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pll_lock_i (pll_lock_i),
  .pdn_ni     (pdn_ni),
  .word_take_o(word_take_o),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .oe_o       (oe_o)
);

// File: tb/ls7_serializer_tb.sv
module ls7_serializer_tb;
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;
  localparam int LOCK  = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pll_lock_i = 1'b1;
  logic             pdn_ni = 1'b1;
  logic [W-1:0]     word_i = '0;
  logic             word_take_o;
  logic [LANES-1:0] lane_o;
  logic             clk_lane_o;
  logic             oe_o;

  int total = 0;
  int bad = 0;
  int frames = 0;
  int pat_idx = 0;
  bit timeout = 0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  ls7_serializer #(
    .LANES(LANES), .SLOTS(SLOTS), .CAP_SLOT(3), .CLK_HIGH(4), .LOCK_CYCLES(LOCK)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pll_lock_i(pll_lock_i), .pdn_ni(pdn_ni),
    .word_i(word_i), .word_take_o(word_take_o), .lane_o(lane_o),
    .clk_lane_o(clk_lane_o), .oe_o(oe_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int i);
    logic [W-1:0] r;
    r = '0;
    case (i % 4)
      0: r = W'(1) << (i % W);
      1: r = '1;
      2: r = {(W/2){2'b10}};
      default: for (int n = 0; n < 7; n++) r[4*n +: 4] = 4'(i + n);
    endcase
    return r;
  endfunction

  // driver: new word at capture slot, junk elsewhere (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && word_take_o) begin
        word_i = pattern(pat_idx);
        pat_idx++;
        exp_q.push_back(word_i);
      end else begin
        word_i = W'($urandom()) ^ (W'($urandom()) << 4);
      end
    end
  end

  // monitor: rebuild frames from the lane pins
  initial begin
    int slot;
    logic prev_clk;
    logic [W-1:0] got, exp;
    slot = -1;
    prev_clk = 1'b0;
    got = '0;
    exp = '0;
    forever begin
      @(negedge clk);
      if (!rst_ni || !oe_o) begin
        slot = -1;
      end else if (clk_lane_o && !prev_clk) begin
        slot = 0;
        while (exp_q.size() > 1) void'(exp_q.pop_front());
        if (exp_q.size() == 1) exp = exp_q.pop_front();
        else slot = -1;
      end else if (slot >= 0) begin
        slot++;
      end
      if (slot >= 0) begin
        for (int k = 0; k < LANES; k++) got[k*SLOTS + slot] = lane_o[k];
        check(clk_lane_o == (slot < 4), "R3 clock lane level", 64'(clk_lane_o),
              64'(slot < 4));
        if (slot == SLOTS - 1) begin
          check(got == exp, "R2 R10 R4 frame word", 64'(got), 64'(exp));
          frames++;
          slot = -1;
        end
      end
      prev_clk = clk_lane_o;
    end
  end

  task automatic wait_oe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!oe_o && n < 500);
  endtask

  task automatic run_all();
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(oe_o == 0 && lane_o == '0 && clk_lane_o == 0, "R9 reset quiet",
          64'({oe_o, lane_o, clk_lane_o}), 64'(0));
    #2 rst_ni = 1'b1;
    wait_oe(n);
    check(n == LOCK * SLOTS, "R6 start-up delay", 64'(n), 64'(LOCK * SLOTS));
    check(clk_lane_o == 1'b1, "R7 enable at frame start", 64'(clk_lane_o), 64'(1));
    repeat (30 * SLOTS) @(negedge clk);

    // power-down mid-frame (R5)
    @(negedge clk);
    #2 pdn_ni = 1'b0;
    #1 check(oe_o == 0 && lane_o == '0 && clk_lane_o == 0, "R5 immediate quiet",
             64'({oe_o, lane_o, clk_lane_o}), 64'(0));
    repeat (20) @(negedge clk);
    check(oe_o == 0 && lane_o == '0 && clk_lane_o == 0, "R5 held quiet",
          64'({oe_o, lane_o, clk_lane_o}), 64'(0));
    #2 pdn_ni = 1'b1;
    wait_oe(n);
    check(n > (LOCK - 1) * SLOTS && n <= LOCK * SLOTS, "R6 relock after power-down",
          64'(n), 64'(LOCK * SLOTS));
    check(clk_lane_o == 1'b1, "R7 enable at frame start", 64'(clk_lane_o), 64'(1));
    repeat (20 * SLOTS) @(negedge clk);

    // lock loss (R8)
    @(negedge clk);
    #2 pll_lock_i = 1'b0;
    @(negedge clk);
    check(oe_o == 0, "R8 lock loss disables", 64'(oe_o), 64'(0));
    repeat (10) @(negedge clk);
    check(oe_o == 0 && lane_o == '0, "R8 stays off", 64'({oe_o, lane_o}), 64'(0));
    #2 pll_lock_i = 1'b1;
    wait_oe(n);
    check(n > (LOCK - 1) * SLOTS && n <= LOCK * SLOTS, "R8 R6 relock delay restarts",
          64'(n), 64'(LOCK * SLOTS));
    repeat (10 * SLOTS) @(negedge clk);
    check(frames >= 50, "R1 R2 frames observed", 64'(frames), 64'(50));
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) check(1'b0, "watchdog", 64'(0), 64'(1));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule